// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This engine moves a block of bytes between a local buffer and a set of memory regions listed in a descriptor table. A one-cycle `start` pulse supplies a table base pointer, a buffer byte count and a direction. The engine then fetches table entries through a word-wide memory read port and cuts the transfer into chunks. No chunk crosses the end of a region. It issues each chunk as one request that carries the region address, the byte count and the local buffer offset.

Each table entry is 8 bytes and is read as two 4-byte requests. The word at the lower address is the region address. The word at the higher address holds the region size in its low half and a final-entry flag in its top bit. The walk ends in one of four ways: the buffer is fully moved; the table runs out first (underrun); the table pointer reaches a one-page limit (also underrun); or a `stop` pulse aborts it at the next chunk boundary.

The controller has six states. **IDLE** waits for `start`. **DECIDE** picks the next step. **FETCH_LO** reads the address word. **FETCH_HI** reads the size/flag word. **MOVE** issues one data chunk. **DONE** raises `done` for one cycle.

The transitions are:
- IDLE→DECIDE on start.
- DECIDE→DONE on a pending stop, an empty buffer, or an exhausted table.
- DECIDE→MOVE while the current region has bytes left.
- DECIDE→FETCH_LO when a new entry is needed.
- FETCH_LO→FETCH_HI on acknowledge.
- FETCH_HI→DECIDE on acknowledge.
- MOVE→DECIDE on acknowledge.
- DONE→IDLE unconditionally.

Top module: `prd_walker`

## Requirements
- R1: After reset `active`, `mem_req` and `done` are low, and no request is made until `start`.
- R2: After `start` the first two requests are descriptor reads (`mem_desc`=1, `mem_we`=0, `mem_bytes`=4) at the base pointer and at base+4. Entry k is read at base+8k and base+8k+4.
- R3: The region address is the whole first word of an entry. The region size is bits 15:0 of the second word with bit 0 forced to zero. Bit 31 of the second word marks the final entry.
- R4: A size field that is zero after masking means a region of 65536 bytes.
- R5: Each data request moves min(buffer bytes left, region bytes left). Afterwards the region address and the buffer offset (`buf_idx`) both advance by that amount.
- R6: A new entry is fetched only when the current region has zero bytes left, and the table pointer then advances by 8.
- R7: On data requests `mem_we` equals the `to_mem` value latched at start: 1 is buffer to memory, 0 is memory to buffer.
- R8: When the buffer count reaches zero, `done` pulses for one cycle with `underrun`=0, no further entry is fetched, and `active` is low on the next cycle. A zero buffer count finishes with no requests.
- R9: If the final entry is used up while buffer bytes remain, `done` pulses with `underrun`=1.
- R10: If the table pointer has advanced 4096 bytes or more past the base, the walk ends with `underrun`=1, so at most 512 entries are read.
- R11: A `stop` pulse lets the outstanding request finish, then the walk issues no further request and ends with `done` and `aborted` high.
- R12: A request holds `mem_req`, `mem_addr`, `mem_bytes` and `mem_desc` steady until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (sampled in IDLE) |
| stop | input | 1 | Abort request, taken at the next chunk boundary |
| base_ptr | input | ADDR_W | Descriptor table base address |
| xfer_len | input | LEN_W | Buffer byte count |
| to_mem | input | 1 | Direction: 1 buffer to memory, 0 memory to buffer |
| mem_req | output | 1 | Memory request valid |
| mem_desc | output | 1 | Request is a descriptor word read |
| mem_we | output | 1 | Request writes memory |
| mem_addr | output | ADDR_W | Request address |
| mem_bytes | output | LEN_W | Request byte count |
| buf_idx | output | LEN_W | Local buffer offset for the data request |
| mem_ack | input | 1 | Request accepted and completed this cycle |
| mem_rdata | input | 32 | Descriptor word returned with `mem_ack` |
| active | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| underrun | output | 1 | With `done`: table ended before the buffer |
| aborted | output | 1 | With `done`: walk ended by `stop` |

## Verification
A wrong region length or address shows up at the very next data request: that request's `mem_addr` or `mem_bytes` differs from the chunk list computed from the table. A stale table pointer shows up within two requests, as a descriptor read at the wrong address. A wrong end decision is seen when the walk ends. A missed final-entry flag or page limit produces an extra descriptor read. A missed buffer-empty test produces an extra request or a wrong `underrun` bit on the `done` cycle.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_MOVE,
        ST_DONE
    } walk_state_e;

    localparam int ENTRY_BYTES = 8;
    localparam int WORD_BYTES  = 4;
    localparam int SIZE_BITS   = 16;
    localparam int FINAL_BIT   = 31;

endpackage

// File: rtl/prd_entry_decode.sv
module prd_entry_decode
    import prd_walk_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic [31:0]      size_word,
    output logic [LEN_W-1:0] region_len,
    output logic             is_final
);
    localparam logic [LEN_W-1:0] FULL_REGION = LEN_W'(1) << SIZE_BITS;

    logic [SIZE_BITS-1:0] even_cnt;

    always_comb begin
        even_cnt = {size_word[SIZE_BITS-1:1], 1'b0};
        if (even_cnt == '0) begin
            region_len = FULL_REGION;
        end else begin
            region_len = LEN_W'(even_cnt);
        end
        is_final = size_word[FINAL_BIT];
    end
endmodule

// File: rtl/prd_chunk_sel.sv
module prd_chunk_sel #(
    parameter int LEN_W = 17
) (
    input  logic [LEN_W-1:0] buf_left,
    input  logic [LEN_W-1:0] region_left,
    output logic [LEN_W-1:0] chunk
);
    always_comb begin
        if (buf_left < region_left) begin
            chunk = buf_left;
        end else begin
            chunk = region_left;
        end
    end
endmodule

// File: rtl/prd_page_guard.sv
module prd_page_guard #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ptr,
    output logic              exhausted
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(PAGE_BYTES);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset    = ptr - base;
        exhausted = (offset >= LIMIT);
    end
endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_walk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 17,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [ADDR_W-1:0] base_ptr,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              to_mem,
    output logic              mem_req,
    output logic              mem_desc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_bytes,
    output logic [LEN_W-1:0]  buf_idx,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              active,
    output logic              done,
    output logic              underrun,
    output logic              aborted
);
    localparam logic [ADDR_W-1:0] STEP_ENTRY = ADDR_W'(ENTRY_BYTES);
    localparam logic [ADDR_W-1:0] STEP_WORD  = ADDR_W'(WORD_BYTES);
    localparam logic [LEN_W-1:0]  WORD_LEN   = LEN_W'(WORD_BYTES);

    walk_state_e state, nxt;

    logic [ADDR_W-1:0] base_r;
    logic [ADDR_W-1:0] tbl_ptr;
    logic [ADDR_W-1:0] rgn_addr;
    logic [LEN_W-1:0]  rgn_left;
    logic [LEN_W-1:0]  buf_left;
    logic [LEN_W-1:0]  idx_r;
    logic              final_r;
    logic              dir_r;
    logic              stop_pend;
    logic              under_r;
    logic              abort_r;

    logic [LEN_W-1:0]  dec_len;
    logic              dec_final;
    logic [LEN_W-1:0]  chunk;
    logic              page_out;
    logic              table_end;

    prd_entry_decode #(.LEN_W(LEN_W)) u_dec (
        .size_word  (mem_rdata),
        .region_len (dec_len),
        .is_final   (dec_final)
    );

    prd_chunk_sel #(.LEN_W(LEN_W)) u_chunk (
        .buf_left    (buf_left),
        .region_left (rgn_left),
        .chunk       (chunk)
    );

    prd_page_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_guard (
        .base      (base_r),
        .ptr       (tbl_ptr),
        .exhausted (page_out)
    );

    assign table_end = final_r | page_out;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (stop_pend) begin
                    nxt = ST_DONE;
                end else if (buf_left == '0) begin
                    nxt = ST_DONE;
                end else if (rgn_left != '0) begin
                    nxt = ST_MOVE;
                end else if (table_end) begin
                    nxt = ST_DONE;
                end else begin
                    nxt = ST_FETCH_LO;
                end
            end
            ST_FETCH_LO: begin
                if (mem_ack) nxt = ST_FETCH_HI;
            end
            ST_FETCH_HI: begin
                if (mem_ack) nxt = ST_DECIDE;
            end
            ST_MOVE: begin
                if (mem_ack) nxt = ST_DECIDE;
            end
            ST_DONE: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_r    <= '0;
            tbl_ptr   <= '0;
            rgn_addr  <= '0;
            rgn_left  <= '0;
            buf_left  <= '0;
            idx_r     <= '0;
            final_r   <= 1'b0;
            dir_r     <= 1'b0;
            stop_pend <= 1'b0;
            under_r   <= 1'b0;
            abort_r   <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                stop_pend <= 1'b0;
            end else if (stop) begin
                stop_pend <= 1'b1;
            end

            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        base_r   <= base_ptr;
                        tbl_ptr  <= base_ptr;
                        rgn_addr <= '0;
                        rgn_left <= '0;
                        buf_left <= xfer_len;
                        idx_r    <= '0;
                        final_r  <= 1'b0;
                        dir_r    <= to_mem;
                        under_r  <= 1'b0;
                        abort_r  <= 1'b0;
                    end
                end
                ST_DECIDE: begin
                    if (stop_pend) begin
                        rgn_addr <= '0;
                        rgn_left <= '0;
                        final_r  <= 1'b0;
                        tbl_ptr  <= '0;
                        abort_r  <= 1'b1;
                    end else if (buf_left != '0 && rgn_left == '0 && table_end) begin
                        under_r <= 1'b1;
                    end
                end
                ST_FETCH_LO: begin
                    if (mem_ack) rgn_addr <= mem_rdata[ADDR_W-1:0];
                end
                ST_FETCH_HI: begin
                    if (mem_ack) begin
                        rgn_left <= dec_len;
                        final_r  <= dec_final;
                        tbl_ptr  <= tbl_ptr + STEP_ENTRY;
                    end
                end
                ST_MOVE: begin
                    if (mem_ack) begin
                        rgn_addr <= rgn_addr + ADDR_W'(chunk);
                        rgn_left <= rgn_left - chunk;
                        buf_left <= buf_left - chunk;
                        idx_r    <= idx_r + chunk;
                    end
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_desc  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_bytes = '0;
        unique case (state)
            ST_FETCH_LO: begin
                mem_req   = 1'b1;
                mem_desc  = 1'b1;
                mem_addr  = tbl_ptr;
                mem_bytes = WORD_LEN;
            end
            ST_FETCH_HI: begin
                mem_req   = 1'b1;
                mem_desc  = 1'b1;
                mem_addr  = tbl_ptr + STEP_WORD;
                mem_bytes = WORD_LEN;
            end
            ST_MOVE: begin
                mem_req   = 1'b1;
                mem_we    = dir_r;
                mem_addr  = rgn_addr;
                mem_bytes = chunk;
            end
            default: begin
            end
        endcase
        buf_idx  = idx_r;
        active   = (state != ST_IDLE);
        done     = (state == ST_DONE);
        underrun = (state == ST_DONE) && under_r;
        aborted  = (state == ST_DONE) && abort_r;
    end
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_desc,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_bytes,
    input logic              mem_ack,
    input logic              active,
    input logic              done,
    input logic              underrun,
    input logic              aborted
);
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);

    a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_bytes) && $stable(mem_desc)));

    a_r2_desc_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_desc) |-> (!mem_we && mem_bytes == LEN_W'(4)));

    a_r5_chunk_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_desc) |-> (mem_bytes != '0));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !active));

    a_r9_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun || aborted) |-> done);

    a_r11_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(underrun && aborted));
endmodule

bind prd_walker prd_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_desc  (mem_desc),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_bytes (mem_bytes),
    .mem_ack   (mem_ack),
    .active    (active),
    .done      (done),
    .underrun  (underrun),
    .aborted   (aborted)
);

// File: tb/prd_walker_tb.sv
module prd_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 17;
    localparam int TBL_WORDS = 2048;
    localparam logic [31:0] TBASE = 32'h0001_0000;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic stop = 1'b0;
    logic [ADDR_W-1:0] base_ptr = '0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic to_mem = 1'b0;
    logic mem_req, mem_desc, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [LEN_W-1:0]  mem_bytes, buf_idx;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic active, done, underrun, aborted;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] tbl [TBL_WORDS];
    logic [31:0] q_addr[$];
    int          q_len[$];
    int          q_idx[$];
    int          exp_fetches;
    bit          exp_under;

    prd_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .base_ptr(base_ptr), .xfer_len(xfer_len), .to_mem(to_mem),
        .mem_req(mem_req), .mem_desc(mem_desc), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_bytes(mem_bytes), .buf_idx(buf_idx),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .active(active),
        .done(done), .underrun(underrun), .aborted(aborted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        logic [31:0] off;
        off = (a - TBASE) >> 2;
        if (a >= TBASE && off < TBL_WORDS) return tbl[off];
        return 32'h0;
    endfunction

    task automatic clear_tbl();
        for (int i = 0; i < TBL_WORDS; i++) tbl[i] = 32'h0;
    endtask

    task automatic put_entry(input logic [31:0] base, input int k,
                             input logic [31:0] addr, input logic [31:0] szw);
        int w;
        w = int'((base - TBASE) >> 2) + 2 * k;
        tbl[w]     = addr;
        tbl[w + 1] = szw;
    endtask

    // expected chunk list computed from the requirements
    task automatic model(input logic [31:0] base, input int len);
        logic [31:0] ptr, ra, w1;
        int rl, rem, idx, c;
        bit fin;
        q_addr.delete(); q_len.delete(); q_idx.delete();
        ptr = base; ra = 0; rl = 0; rem = len; idx = 0; fin = 0;
        exp_fetches = 0; exp_under = 0;
        while (1) begin
            if (rem == 0) break;
            if (rl != 0) begin
                c = (rem < rl) ? rem : rl;
                q_addr.push_back(ra); q_len.push_back(c); q_idx.push_back(idx);
                ra = ra + 32'(c); rl = rl - c; rem = rem - c; idx = idx + c;
                continue;
            end
            if (fin || (ptr - base) >= 32'd4096) begin
                exp_under = 1;
                break;
            end
            ra = rd(ptr);
            w1 = rd(ptr + 4);
            rl = int'({w1[15:1], 1'b0});
            if (rl == 0) rl = 65536;
            fin = w1[31];
            ptr = ptr + 8;
            exp_fetches++;
        end
    endtask

    task automatic run_walk(input logic [31:0] base, input int len, input bit dir,
                            input int stop_at, input string tag);
        int desc_reqs, chunks, waitc, cyc;
        bit got_done, g_under, g_abort, held;
        logic [31:0] held_addr;
        logic [31:0] ea;
        int el, ei;
        model(base, len);
        @(negedge clk);
        start = 1'b1; base_ptr = base; xfer_len = LEN_W'(len); to_mem = dir;
        @(negedge clk);
        start = 1'b0;
        desc_reqs = 0; chunks = 0; waitc = $urandom % 3; got_done = 0;
        g_under = 0; g_abort = 0; held = 0; held_addr = 0;
        for (cyc = 0; cyc < 40000; cyc++) begin
            if (cyc != 0) @(negedge clk);
            if (stop) stop = 1'b0;
            if (held) begin
                chk(mem_req && mem_addr == held_addr, "R12", {tag, " request held"},
                    mem_addr, held_addr);
                held = 0;
            end
            if (mem_ack) begin
                mem_ack = 1'b0;
                continue;
            end
            if (done) begin
                got_done = 1; g_under = underrun; g_abort = aborted;
                break;
            end
            if (!mem_req) continue;
            if (waitc > 0) begin
                waitc--;
                held = 1; held_addr = mem_addr;
                continue;
            end
            if (mem_desc) begin
                chk(mem_addr == base + 32'(4 * desc_reqs) && !mem_we, "R2",
                    {tag, " descriptor read address"}, mem_addr, base + 32'(4 * desc_reqs));
                mem_rdata = rd(mem_addr);
                desc_reqs++;
            end else begin
                if (q_addr.size() == 0) begin
                    chk(0, "R8", {tag, " unexpected data request"}, mem_addr, 0);
                end else begin
                    ea = q_addr.pop_front(); el = q_len.pop_front(); ei = q_idx.pop_front();
                    chk(mem_addr == ea, "R3", {tag, " region address"}, mem_addr, ea);
                    chk(int'(mem_bytes) == el, "R5", {tag, " chunk bytes"}, mem_bytes, el);
                    chk(int'(buf_idx) == ei, "R5", {tag, " buffer offset"}, buf_idx, ei);
                    chk(mem_we == dir, "R7", {tag, " direction"}, mem_we, dir);
                end
                chunks++;
                if (chunks == stop_at) stop = 1'b1;
            end
            mem_ack = 1'b1;
            waitc = $urandom % 3;
        end
        chk(got_done, "R8", {tag, " done seen"}, got_done, 1);
        if (stop_at > 0) begin
            chk(g_abort && !g_under, "R11", {tag, " aborted flag"}, g_abort, 1);
            chk(chunks == stop_at, "R11", {tag, " no request after stop"}, chunks, stop_at);
        end else begin
            chk(g_under == exp_under && !g_abort, (exp_under ? "R9" : "R8"),
                {tag, " underrun flag"}, g_under, exp_under);
            chk(q_addr.size() == 0, "R5", {tag, " all chunks issued"}, q_addr.size(), 0);
            chk(desc_reqs == 2 * exp_fetches, "R6", {tag, " descriptor fetch count"},
                desc_reqs, 2 * exp_fetches);
        end
        @(negedge clk);
        chk(!active, "R8", {tag, " active low after done"}, active, 0);
    endtask

    initial begin
        logic [31:0] b;
        int n, cnt, blen;
        bit keep_final;
        void'($urandom(32'd1234));
        clear_tbl();
        repeat (3) @(negedge clk);
        chk(!active && !mem_req && !done, "R1", "reset state", {active, mem_req, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!active && !mem_req && !done, "R1", "idle after reset", {active, mem_req, done}, 0);

        // R8: empty buffer finishes with no requests
        clear_tbl();
        put_entry(TBASE, 0, 32'h2000_0000, 32'h8000_0010);
        run_walk(TBASE, 0, 0, 0, "R8 empty buffer");

        // R3, R9: odd count is masked, final flag ends the table early
        clear_tbl();
        put_entry(TBASE, 0, 32'h3000_0101, 32'h8000_0007);
        run_walk(TBASE, 10, 0, 0, "R3 R9 odd count");

        // R4: zero size field means 65536 bytes
        clear_tbl();
        put_entry(TBASE + 64, 0, 32'h4000_0000, 32'h8000_0000);
        run_walk(TBASE + 64, 65536 + 10, 1, 0, "R4 full region");

        // R5, R7, R8: finish inside a region, further entries untouched
        clear_tbl();
        put_entry(TBASE, 0, 32'h5000_0000, 32'h0000_0064);
        put_entry(TBASE, 1, 32'h5100_0000, 32'h0000_0064);
        put_entry(TBASE, 2, 32'h5200_0000, 32'h8000_0064);
        run_walk(TBASE, 150, 1, 0, "R5 R7 R8 mid-region");

        // R10: one-page limit on an unterminated table
        clear_tbl();
        for (int k = 0; k < 520; k++) put_entry(TBASE, k, 32'h6000_0000 + 32'(16 * k), 32'h0000_0002);
        run_walk(TBASE, 5000, 0, 0, "R10 page limit");

        // R11: stop after second chunk
        clear_tbl();
        for (int k = 0; k < 4; k++) put_entry(TBASE, k, 32'h7000_0000 + 32'(4096 * k), 32'h0000_0040);
        run_walk(TBASE, 1000, 1, 2, "R11 stop");

        // R11 then a clean walk after abort (R6)
        run_walk(TBASE, 100, 0, 0, "R6 after abort");

        // constrained random walks (R5, R6)
        for (int t = 0; t < 24; t++) begin
            clear_tbl();
            b = TBASE + 32'(8 * ($urandom % 64));
            n = 1 + ($urandom % 6);
            keep_final = ($urandom % 4) != 0;
            for (int k = 0; k < n; k++) begin
                cnt = ($urandom % 8 == 0) ? 0 : int'($urandom % 1500);
                put_entry(b, k, $urandom,
                          ((k == n - 1 && keep_final) ? 32'h8000_0000 : 32'h0) | 32'(cnt)
                          | ($urandom & 32'h7FFF_0000));
            end
            blen = int'($urandom % 4000);
            run_walk(b, blen, 1'($urandom), 0, "R5 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule